// File: doc/BRIEF.md
# Supply Discharge-Time Measurement Counter

This block turns the time a disconnected supply node needs to decay to a reference level into a binary word. A measurement begins with a request. The supply switch first stays closed through a settling pause, so that the node can recover from stimulus activity. It then stays closed through a comparator stabilisation phase used for offset cancellation. After that the switch is opened, and after an optional programmed delay a count window starts. During the window the counter advances on every cycle where the selected count clock enable is high. The window closes on the first cycle, after a blanking interval, in which the synchronised comparator bit reports that the node has fallen below the reference.

The final count is latched into a result register and announced by a one-cycle valid strobe. The switch re-closes in the same cycle. A programmable limit cuts off a window that runs too long, for example with a stuck switch or comparator. In that case the result is forced to all ones and an overflow flag accompanies it. The counted value is inversely related to the quiescent current of the circuit behind the switch, and a later stage compares these values across test patterns.

Top module: `discharge_timer`

## Requirements
- R1: While reset is asserted and directly after it, sw_open_o, valid_o and ovf_o are 0 and count_o is 0.
- R2: When start_i is sampled high with the block idle, sw_open_o stays 0 for a settling phase of pause_cyc_i+1 cycles and a stabilisation phase of stab_cyc_i+1 cycles. It goes to 1 on the clock edge pause_cyc_i+stab_cyc_i+2 edges after the edge that sampled start_i (1 means supply disconnected).
- R3: The count window begins open_dly_i+1 cycles after sw_open_o rises, with the counter at zero. Inside the window the counter advances by one on each cycle where cnt_en_i is 1 and holds where it is 0.
- R4: cmp_i=1 means the node is above the reference. It passes through two flip-flops before use. After blanking, the window ends on the first cycle in which the synchronised value is 0, and the count reached by then becomes the result.
- R5: During the first blank_cyc_i cycles of the window the comparator is ignored. With cmp_i held at 0 and cnt_en_i at 1, the result equals blank_cyc_i, including 0.
- R6: If the counter equals ovf_limit_i on a window cycle with cnt_en_i=1 and no comparator end, the measurement stops, count_o becomes all ones and ovf_o becomes 1. A normal end clears ovf_o.
- R7: valid_o is a one-cycle pulse. It rises in the same cycle that sw_open_o returns to 0, and count_o and ovf_o hold their values until the next pulse.
- R8: start_i is ignored while a measurement is in progress, so one request opens the switch exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Measurement request |
| cmp_i | input | 1 | Asynchronous comparator bit, 1 = node above reference |
| cnt_en_i | input | 1 | Enable from the selected count clock |
| ovf_limit_i | input | CNT_W | Highest count before overflow cut-off |
| pause_cyc_i | input | DLY_W | Settling pause length minus one |
| stab_cyc_i | input | DLY_W | Comparator stabilisation length minus one |
| open_dly_i | input | DLY_W | Delay from switch opening to window start, minus one |
| blank_cyc_i | input | DLY_W | Window cycles in which the comparator is ignored |
| sw_open_o | output | 1 | 1 = supply switch open (node floating) |
| count_o | output | CNT_W | Result register |
| valid_o | output | 1 | One-cycle result strobe |
| ovf_o | output | 1 | Result came from the overflow cut-off |

## Verification
The bench builds the block with CNT_W=8 and DLY_W=4. The narrow count width lets the all-ones overflow code, and a limit equal to that code, be reached within a few hundred cycles. The 4-bit phase fields keep every phase length, from zero up to its maximum, short enough to sweep. A behavioural model tracks the comparator through its two-cycle lag and is compared with the outputs on every cycle. Its scenarios include comparator ends hidden by blanking, sparse count enables, zero limits and repeated requests during a measurement.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CAL    = 3'd2,
    ST_DELAY  = 3'd3,
    ST_COUNT  = 3'd4
  } dtm_state_e;
endpackage

// File: rtl/dtm_sync.sv
module dtm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dtm_seq.sv
module dtm_seq
  import dtm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic             ovf_hit_i,
  input  logic [DLY_W-1:0] pause_i,
  input  logic [DLY_W-1:0] stab_i,
  input  logic [DLY_W-1:0] open_dly_i,
  input  logic [DLY_W-1:0] blank_i,
  output logic             sw_open_o,
  output logic             clr_o,
  output logic             run_o,
  output logic             done_cmp_o,
  output logic             done_ovf_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  dtm_state_e       state_q, state_d;
  logic [DLY_W-1:0] tmr_q, tmr_d;
  logic             blank;

  assign run_o      = (state_q == ST_COUNT);
  assign blank      = (tmr_q != '0);
  assign done_cmp_o = run_o && !blank && !cmp_s_i;
  assign done_ovf_o = run_o && !done_cmp_o && ovf_hit_i;
  assign sw_open_o  = (state_q == ST_DELAY) || (state_q == ST_COUNT);

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SETTLE;
          tmr_d   = pause_i;
        end
      end
      ST_SETTLE: begin
        if (tmr_q == '0) begin
          state_d = ST_CAL;
          tmr_d   = stab_i;
        end else begin
          tmr_d = tmr_q - ONE;
        end
      end
      ST_CAL: begin
        if (tmr_q == '0) begin
          state_d = ST_DELAY;
          tmr_d   = open_dly_i;
        end else begin
          tmr_d = tmr_q - ONE;
        end
      end
      ST_DELAY: begin
        if (tmr_q == '0) begin
          state_d = ST_COUNT;
          tmr_d   = blank_i;
          clr_o   = 1'b1;
        end else begin
          tmr_d = tmr_q - ONE;
        end
      end
      ST_COUNT: begin
        if (blank) tmr_d = tmr_q - ONE;
        if (done_cmp_o || done_ovf_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  // R2: the switch only opens straight out of the stabilisation phase
  a_r2_open_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_open_o) |-> ($past(state_q) == ST_CAL));

  // R8: a request seen mid-measurement never restarts the settling phase
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != ST_IDLE && state_q != ST_SETTLE) |=> (state_q != ST_SETTLE));
endmodule

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             done_cmp_i,
  input  logic             done_ovf_i,
  output logic             ovf_hit_o,
  output logic [CNT_W-1:0] res_o,
  output logic             ovf_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             ovf_q, ovf_d;
  logic             valid_q;
  logic             inc;

  assign ovf_hit_o = run_i && cnt_en_i && (cnt_q == limit_i);
  assign inc       = run_i && cnt_en_i && !ovf_hit_o && !done_cmp_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)    cnt_d = '0;
    else if (inc) cnt_d = cnt_q + STEP;
  end

  always_comb begin
    res_d = res_q;
    ovf_d = ovf_q;
    if (done_cmp_i) begin
      res_d = cnt_q;
      ovf_d = 1'b0;
    end else if (done_ovf_i) begin
      res_d = ALL_ONES;
      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      res_q   <= '0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      res_q   <= res_d;
      ovf_q   <= ovf_d;
      valid_q <= done_cmp_i || done_ovf_i;
    end
  end

  assign res_o   = res_q;
  assign ovf_o   = ovf_q;
  assign valid_o = valid_q;

  // R3: a window cycle without count enable leaves the counter unchanged
  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !cnt_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/discharge_timer.sv
module discharge_timer #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             cnt_en_i,
  input  logic [CNT_W-1:0] ovf_limit_i,
  input  logic [DLY_W-1:0] pause_cyc_i,
  input  logic [DLY_W-1:0] stab_cyc_i,
  input  logic [DLY_W-1:0] open_dly_i,
  input  logic [DLY_W-1:0] blank_cyc_i,
  output logic             sw_open_o,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             ovf_o
);
  localparam int SYNC_STAGES = 2;

  logic cmp_s;
  logic clr, run, done_cmp, done_ovf, ovf_hit;

  dtm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dtm_seq #(.DLY_W(DLY_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmp_s_i    (cmp_s),
    .ovf_hit_i  (ovf_hit),
    .pause_i    (pause_cyc_i),
    .stab_i     (stab_cyc_i),
    .open_dly_i (open_dly_i),
    .blank_i    (blank_cyc_i),
    .sw_open_o  (sw_open_o),
    .clr_o      (clr),
    .run_o      (run),
    .done_cmp_o (done_cmp),
    .done_ovf_o (done_ovf)
  );

  dtm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .run_i      (run),
    .cnt_en_i   (cnt_en_i),
    .limit_i    (ovf_limit_i),
    .done_cmp_i (done_cmp),
    .done_ovf_i (done_ovf),
    .ovf_hit_o  (ovf_hit),
    .res_o      (count_o),
    .ovf_o      (ovf_o),
    .valid_o    (valid_o)
  );

  // R7: strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7: switch is closed whenever a result is announced
  a_r7_closed_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !sw_open_o);

  // R7: result register holds between strobes
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(count_o) && $stable(ovf_o)));

  // R6: an overflow result always carries the all-ones code
  a_r6_ovf_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovf_o) |-> (count_o == {CNT_W{1'b1}}));
endmodule

// File: tb/test_discharge_timer.sv
module test_discharge_timer;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int ONES = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i = 1'b1;
  logic          cnt_en_i = 1'b0;
  logic [CW-1:0] ovf_limit_i = '0;
  logic [DW-1:0] pause_cyc_i = '0;
  logic [DW-1:0] stab_cyc_i = '0;
  logic [DW-1:0] open_dly_i = '0;
  logic [DW-1:0] blank_cyc_i = '0;
  logic          sw_open_o;
  logic [CW-1:0] count_o;
  logic          valid_o;
  logic          ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  discharge_timer #(.CNT_W(CW), .DLY_W(DW)) i_discharge_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .cnt_en_i(cnt_en_i), .ovf_limit_i(ovf_limit_i),
    .pause_cyc_i(pause_cyc_i), .stab_cyc_i(stab_cyc_i),
    .open_dly_i(open_dly_i), .blank_cyc_i(blank_cyc_i),
    .sw_open_o(sw_open_o), .count_o(count_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase names and cycle budgets from the requirements
  int m_phase, m_left, m_cnt, m_res, m_ovf, m_valid, m_h1, m_h2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_cnt = 0; m_res = 0; m_ovf = 0; m_valid = 0;
      m_h1 = 0; m_h2 = 0;
    end else begin
      int seen;
      bit ignore;
      seen = m_h2;
      m_h2 = m_h1;
      m_h1 = int'(cmp_i);
      m_valid = 0;
      case (m_phase)
        0: if (start_i) begin m_phase = 1; m_left = int'(pause_cyc_i); end
        1: if (m_left == 0) begin m_phase = 2; m_left = int'(stab_cyc_i); end else m_left--;
        2: if (m_left == 0) begin m_phase = 3; m_left = int'(open_dly_i); end else m_left--;
        3: if (m_left == 0) begin m_phase = 4; m_left = int'(blank_cyc_i); m_cnt = 0; end else m_left--;
        default: begin
          ignore = (m_left > 0);
          if (ignore) m_left--;
          if (!ignore && seen == 0) begin
            m_res = m_cnt; m_ovf = 0; m_valid = 1; m_phase = 0;
          end else if (cnt_en_i) begin
            if (m_cnt == int'(ovf_limit_i)) begin
              m_res = ONES; m_ovf = 1; m_valid = 1; m_phase = 0;
            end else m_cnt++;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int msw;
      msw = (m_phase == 3 || m_phase == 4) ? 1 : 0;
      chk(int'(sw_open_o) == msw, "R2 switch", int'(sw_open_o), msw);
      chk(int'(valid_o) == m_valid, "R7 valid", int'(valid_o), m_valid);
      chk(int'(count_o) == m_res, "R4 result", int'(count_o), m_res);
      chk(int'(ovf_o) == m_ovf, "R6 overflow", int'(ovf_o), m_ovf);
    end
  end

  // en_mode: 0 always, 1 every other cycle, 2 every third, 3 never
  task automatic measure(input int pause, input int stab, input int dly, input int blank,
                         input int lim, input int drop_at, input int en_mode, input bit spam,
                         output int res, output int ovf, output int open_lat, output int opens);
    int prev_sw;
    @(negedge clk); #1;
    pause_cyc_i = DW'(pause); stab_cyc_i = DW'(stab); open_dly_i = DW'(dly);
    blank_cyc_i = DW'(blank); ovf_limit_i = CW'(lim);
    start_i = 1'b1; cmp_i = (drop_at > 0); cnt_en_i = (en_mode != 3);
    open_lat = -1; opens = 0; prev_sw = 0; res = -1; ovf = -1;
    for (int k = 1; k < 2000; k++) begin
      @(negedge clk);
      if (sw_open_o && !prev_sw) begin
        opens++;
        if (open_lat < 0) open_lat = k;
      end
      prev_sw = int'(sw_open_o);
      if (valid_o) begin
        res = int'(count_o); ovf = int'(ovf_o);
        break;
      end
      #1;
      start_i  = spam && (k % 7 == 0);
      cmp_i    = (k < drop_at);
      cnt_en_i = (en_mode == 0) || (en_mode == 1 && k % 2 == 0) || (en_mode == 2 && k % 3 == 0);
    end
    #1; start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(int'(count_o) == res && !valid_o && !sw_open_o, "R7 hold after strobe",
          int'(count_o), res);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int res, ovf, lat, opens;
    repeat (3) @(negedge clk);
    chk(!sw_open_o && !valid_o && !ovf_o && count_o == 0, "R1 in reset", int'(count_o), 0);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!sw_open_o && !valid_o && !ovf_o && count_o == 0, "R1 after reset", int'(count_o), 0);

    // Blanking covers a low comparator: result equals blank length
    measure(2, 3, 1, 4, 200, 0, 0, 0, res, ovf, lat, opens);
    chk(lat == 2 + 3 + 3, "R2 opening latency", lat, 8);
    chk(res == 4 && ovf == 0, "R5 blank length result", res, 4);

    // No blanking, low comparator: immediate end with zero
    measure(0, 0, 0, 0, 200, 0, 0, 0, res, ovf, lat, opens);
    chk(lat == 3, "R2 zero phases latency", lat, 3);
    chk(res == 0 && ovf == 0, "R5 zero blank result", res, 0);

    // Comparator drop with sparse enable, checked by model every cycle
    measure(1, 2, 4, 2, 200, 30, 1, 0, res, ovf, lat, opens);
    chk(ovf == 0 && res > 0, "R4 normal end", res, 1);

    // Window with no count enable stays at zero
    measure(1, 0, 2, 2, 200, 25, 3, 0, res, ovf, lat, opens);
    chk(res == 0 && ovf == 0, "R3 no enable no count", res, 0);

    // Open delay change moves window, every-third enable
    measure(0, 0, 5, 3, 200, 18, 2, 0, res, ovf, lat, opens);
    chk(ovf == 0, "R3 delayed window end", ovf, 0);

    // Stuck comparator: overflow at limit
    measure(0, 1, 0, 1, 10, 5000, 0, 0, res, ovf, lat, opens);
    chk(res == ONES && ovf == 1, "R6 overflow code", res, ONES);

    // Limit zero overflows on the first enabled cycle
    measure(0, 0, 0, 0, 0, 5000, 0, 0, res, ovf, lat, opens);
    chk(res == ONES && ovf == 1, "R6 zero limit", res, ONES);

    // Limit at the all-ones code
    measure(0, 0, 0, 0, ONES, 5000, 0, 0, res, ovf, lat, opens);
    chk(res == ONES && ovf == 1, "R6 full-range limit", res, ONES);

    // Normal end after overflow clears the flag
    measure(3, 1, 1, 0, 200, 20, 0, 0, res, ovf, lat, opens);
    chk(ovf == 0, "R6 flag cleared", ovf, 0);

    // Repeated requests during a measurement
    measure(4, 4, 3, 1, 200, 40, 0, 1, res, ovf, lat, opens);
    chk(opens == 1, "R8 single opening", opens, 1);

    // Maximum phase lengths
    measure(15, 15, 15, 15, 200, 60, 0, 0, res, ovf, lat, opens);
    chk(lat == 33, "R2 max phase latency", lat, 33);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule